// File: doc/BRIEF.md
# Timing-Reference Word-Alignment Framer

This block sits after descrambling and NRZI decoding in a serial digital video receive path. It takes a stream of 10-bit characters whose boundaries have no fixed relation to the true word boundaries of the video data. It looks for the 30-bit timing-reference marker at every one of the ten possible bit offsets, and it re-slices the stream so that the characters it outputs fall on correct 10-bit boundaries.

Within each input word, bit 0 is the earliest bit in serial order. The marker is ten ones followed by twenty zeros in serial order. Once aligned, this appears as the word sequence 3FF, 000, 000.

On every clock the block checks a 40-bit window. The window holds the current input word and the three words before it. An enable input decides whether a detected marker may move the alignment. A one-cycle sync pulse marks the output of the last marker word. A one-cycle error flag reports a marker found at an offset other than the one in use.

Top module: `trs_framer`

## Requirements
- R1: After reset, `dataOut` is 0, and `hSync`, `syncErr` and `isLocked` are all low.
- R2: The marker is recognised when serial stream bits P to P+9 are ones and bits P+10 to P+29 are zeros. The offset is P mod 10, and every offset from 0 to 9 is detected. Serial bit 10·t+i is `dataIn[i]` of input word t.
- R3: With active offset s, the `dataOut` value that follows the clock edge sampling input word t equals serial bits 10·(t−1)+s through 10·(t−1)+s+9. Serial bit 10·(t−1)+s appears on `dataOut[0]`.
- R4: When `syncEn` is high and a marker is found at offset k, the active offset becomes k. The new offset already applies to the output produced in the detection cycle.
- R5: `hSync` is high for exactly one cycle. That cycle is the output produced when the last word of the marker is sampled, so `dataOut` shows the final 000 word of the marker.
- R6: While `syncEn` is low, a detected marker does not change the active offset or the lock state. A marker at an offset other than the active one gives no `hSync`.
- R7: When the framer is locked and a marker is found at an offset different from the active one, `syncErr` is high for one cycle. This holds whatever the level of `syncEn`.
- R8: A marker found at the active offset while locked gives `hSync` and no `syncErr`, whatever the level of `syncEn`.
- R9: While unlocked, `syncErr` stays low. A marker seen with `syncEn` low leaves the framer unlocked and gives no `hSync`.
- R10: `isLocked` rises on the first marker seen with `syncEn` high, and it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncEn | input | 1 | Permits a detected marker to move the alignment |
| dataIn | input | 10 | Unaligned character from the descrambler |
| dataOut | output | 10 | Aligned character |
| hSync | output | 1 | One-cycle pulse on the output of the final marker word |
| syncErr | output | 1 | One-cycle flag for a marker at a foreign offset while locked |
| isLocked | output | 1 | High once an alignment has been accepted |

## Verification
The bench places the marker at each of the ten offsets in turn, with successive offsets always different. This exposes a window slice that is off by one bit, a reversed bit order, and a shifted output that lags its own sync pulse. A design that applied the new offset one cycle late would emit a wrongly sliced 000 word under `hSync`.

With `syncEn` low, a marker at a foreign offset must raise only `syncErr` and leave the old slicing intact. A marker at the active offset must give `hSync` without an error. A design that realigned anyway, or that flagged matching markers as errors, would fail these cases.

The bench also feeds a marker to a freshly reset framer with `syncEn` low. This catches an error flag raised before any lock exists, and a lock taken without permission.

// File: rtl/trs_pkg.sv
package trs_pkg;
  localparam int WORD_W     = 10;
  localparam int HIST_WORDS = 4;
  localparam int WIN_W      = WORD_W * HIST_WORDS;
  localparam int OFF_W      = $clog2(WORD_W);
  localparam int TAIL_POS   = 2 * WORD_W;

  typedef struct packed {
    logic [OFF_W-1:0] selOff;
  } trs_ctl_t;
endpackage

// File: rtl/trs_datapath.sv
module trs_datapath
  import trs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] dataIn,
  input  trs_ctl_t          ctl,
  output logic [WORD_W-1:0] hitVec,
  output logic [WORD_W-1:0] dataOut
);
  logic [WIN_W-WORD_W-1:0] histReg;
  logic [WIN_W-1:0]        window;

  assign window = {dataIn, histReg};

  // one comparator per candidate offset: ten ones then twenty zeros
  for (genvar k = 0; k < WORD_W; k++) begin : g_cmp
    assign hitVec[k] = (&window[k +: WORD_W]) &&
                       (window[k + WORD_W +: 2 * WORD_W] == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histReg <= '0;
      dataOut <= '0;
    end else begin
      histReg <= window[WIN_W-1:WORD_W];
      dataOut <= window[TAIL_POS + int'(ctl.selOff) +: WORD_W];
    end
  end
endmodule

// File: rtl/trs_control.sv
module trs_control
  import trs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncEn,
  input  logic [WORD_W-1:0] hitVec,
  output trs_ctl_t          ctl,
  output logic              hSync,
  output logic              syncErr,
  output logic              isLocked
);
  logic [OFF_W-1:0] offReg;
  logic [OFF_W-1:0] hitOff;
  logic [OFF_W-1:0] offNext;
  logic             hitAny;
  logic             lockNext;

  always_comb begin
    hitOff = '0;
    for (int k = WORD_W - 1; k >= 0; k--) begin
      if (hitVec[k]) hitOff = OFF_W'(k);
    end
  end

  assign hitAny   = |hitVec;
  assign offNext  = (hitAny && syncEn) ? hitOff : offReg;
  assign lockNext = isLocked || (hitAny && syncEn);
  assign ctl.selOff = offNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offReg   <= '0;
      isLocked <= 1'b0;
      hSync    <= 1'b0;
      syncErr  <= 1'b0;
    end else begin
      offReg   <= offNext;
      isLocked <= lockNext;
      hSync    <= hitAny && lockNext && (hitOff == offNext);
      syncErr  <= hitAny && isLocked && (hitOff != offReg);
    end
  end
endmodule

// File: rtl/trs_framer.sv
module trs_framer
  import trs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncEn,
  input  logic [WORD_W-1:0] dataIn,
  output logic [WORD_W-1:0] dataOut,
  output logic              hSync,
  output logic              syncErr,
  output logic              isLocked
);
  trs_ctl_t          ctl;
  logic [WORD_W-1:0] hitVec;

  trs_datapath dp_i (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .ctl(ctl),
    .hitVec(hitVec), .dataOut(dataOut)
  );

  trs_control ctl_i (
    .clk(clk), .rstN(rstN), .syncEn(syncEn), .hitVec(hitVec),
    .ctl(ctl), .hSync(hSync), .syncErr(syncErr), .isLocked(isLocked)
  );
endmodule

// File: rtl/trs_framer_checker.sv
module trs_framer_checker (
  input logic clk,
  input logic rstN,
  input logic syncEn,
  input logic hSync,
  input logic syncErr,
  input logic isLocked
);
  a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    isLocked |=> isLocked);
  a_r6_hold_lock: assert property (@(posedge clk) disable iff (!rstN)
    !syncEn |=> (isLocked == $past(isLocked)));
  a_r9_no_err_unlocked: assert property (@(posedge clk) disable iff (!rstN)
    !isLocked |=> !syncErr);
  a_r5_hsync_single: assert property (@(posedge clk) disable iff (!rstN)
    hSync |=> !hSync);
  a_r7_err_single: assert property (@(posedge clk) disable iff (!rstN)
    syncErr |=> !syncErr);
  a_r5_hsync_locked: assert property (@(posedge clk) disable iff (!rstN)
    hSync |-> isLocked);
endmodule

bind trs_framer trs_framer_checker chk_i (
  .clk(clk), .rstN(rstN), .syncEn(syncEn), .hSync(hSync),
  .syncErr(syncErr), .isLocked(isLocked)
);

// File: tb/trs_framer_tb.sv
module trs_framer_tb_top;
  localparam int W  = 10;
  localparam int NW = 12;
  localparam int NB = W * NW;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         syncEn = 1'b0;
  logic [W-1:0] dataIn = '0;
  logic [W-1:0] dataOut;
  logic         hSync, syncErr, isLocked;

  int compared = 0;
  int mismatched = 0;
  int expOff = 0;
  bit expLock = 1'b0;
  bit strm [NB];
  bit finished = 1'b0;

  always #2 clk = ~clk;

  trs_framer dut_i (
    .clk(clk), .rstN(rstN), .syncEn(syncEn), .dataIn(dataIn),
    .dataOut(dataOut), .hSync(hSync), .syncErr(syncErr), .isLocked(isLocked)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // build a stream: filler never has ten ones in a row (bit i%7==0 forced 0)
  task automatic build(int k, int seed);
    for (int i = 0; i < NB; i++)
      strm[i] = (i % 7 == 0) ? 1'b0 : (((i * 13 + seed * 5 + (i >> 3)) % 3) != 0);
    if (k >= 0) begin
      for (int i = 0; i < 30; i++) strm[30 + k + i] = (i < 10);
    end
  endtask

  // marker at bit 30+k -> detected when word 6 is sampled
  task automatic run(int k, bit en, int seed, string tag);
    build(k, seed);
    for (int t = 0; t < NW; t++) begin
      bit det, hsExp, errExp;
      logic [W-1:0] w, dExp;
      @(negedge clk);
      for (int i = 0; i < W; i++) w[i] = strm[W * t + i];
      dataIn = w;
      syncEn = en;
      det = (k >= 0) && (t == 6);
      errExp = det && expLock && (k != expOff);
      if (det && en) begin
        expOff = k;
        expLock = 1'b1;
      end
      hsExp = det && expLock && (k == expOff);
      @(posedge clk);
      #1;
      check({tag, " R5/R8 hSync"}, W'(hSync), W'(hsExp));
      check({tag, " R7/R9 syncErr"}, W'(syncErr), W'(errExp));
      check({tag, " R10 isLocked"}, W'(isLocked), W'(expLock));
      if (t >= 1) begin
        for (int i = 0; i < W; i++) dExp[i] = strm[W * (t - 1) + expOff + i];
        check({tag, " R3/R4 dataOut"}, dataOut, dExp);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 dataOut", dataOut, '0);
    check("R1 hSync", W'(hSync), '0);
    check("R1 syncErr", W'(syncErr), '0);
    check("R1 isLocked", W'(isLocked), '0);
    @(negedge clk);
    rstN = 1'b1;
    run(0, 1'b0, 1, "R9 unlocked-noen");
    begin
      int offs [10] = '{3, 0, 9, 1, 8, 2, 7, 4, 6, 5};
      foreach (offs[j]) run(offs[j], 1'b1, j + 2, "R2 sweep");
    end
    run(5, 1'b1, 20, "R8 same-en");
    run(2, 1'b0, 21, "R6 foreign-noen");
    run(5, 1'b0, 22, "R8 same-noen");
    run(-1, 1'b1, 23, "R4 nomarker");
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule